// File: doc/BRIEF.md
# SD Card Clock Divider Controller

This block derives the SD card clock from a fast base clock and is programmed through one 32-bit control word. Software writes a 10-bit divisor, an internal-clock enable, a card-clock enable and a 4-bit data-timeout exponent. The block reports when the divided clock has settled. A divisor N above zero gives a card clock of base/(2·N), high for N base cycles and low for N base cycles. A divisor of zero passes the base clock straight through.

The same word holds three self-clearing reset requests, one each for the whole host, the command circuit and the data circuit. Each drives a pulse output that the command and data paths use, and each request bit reads back as 1 while its pulse is active. A host reset also returns the divisor and both enables to zero. The block has no streaming data path. Every pin is plain control or status: a write takes effect on the clock edge where `ctrl_wr` is high, and the block never back-pressures.

Top module: `sdclk_ctrl`

## Requirements
- R1: The divisor is split over two fields. Bits [15:8] hold its low 8 bits and bits [7:6] hold its top 2 bits. A read returns both fields as written.
- R2: With divisor N (1 to 1023), the card clock runs continuously once started. Each high phase lasts exactly N base cycles and each low phase lasts exactly N base cycles.
- R3: With divisor 0, the card clock follows the base clock while it is running. It is high in the high half of each base cycle and low in the low half.
- R4: Bit 1 (read-only) and `clk_stable` go to 1 exactly SETTLE_CYC+1 base cycles after the write edge that sets bit 0 or changes the divisor, provided bit 0 is 1.
- R5: The stable flag drops right after a write edge that changes the divisor, and it drops when bit 0 is cleared. A write that keeps the same divisor and bit 0 leaves the flag at 1.
- R6: The card clock is held low while bit 2 is 0 or the stable flag is 0. A high phase already under way still completes its full N cycles before the clock stops.
- R7: Bit 5 reads as 0 and writes to it are ignored, so only divided mode is in effect. Writes to bit 1 are ignored. All bits not named in R1, R4, R6, R8 and R9 read as 0.
- R8: Bits [19:16] hold the timeout exponent. They are loaded on every write, read back unchanged, and are not cleared by a host reset.
- R9: Writing 1 to bit 24, 25 or 26 starts a host, command or data reset. The matching bit reads 1 and the matching pulse output is high for exactly RST_CYC cycles, starting right after the write edge. The bit then clears itself.
- R10: A host reset clears the divisor, bit 0 and bit 2 to 0, and keeps them at 0 while its pulse lasts.
- R11: After `rst_n` is low, the control word reads as 0 and `card_clk`, `clk_stable` and all reset pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 32 | Control word value to write |
| ctrl_rdata | output | 32 | Current control word readback |
| card_clk | output | 1 | Gated card clock |
| clk_stable | output | 1 | Divided clock has settled |
| host_rst | output | 1 | Host reset pulse |
| cmd_rst | output | 1 | Command circuit reset pulse |
| data_rst | output | 1 | Data circuit reset pulse |

## Verification
The divider is run with random divisors drawn from a small range, and with the corner values 1, 1023 and 0. These show whether half-periods are counted as N, N−1 or N+1, and whether the pass-through path is ever taken by mistake. Stable-flag tests compare a write that changes the divisor with one that rewrites the same value, and they also clear the internal enable. This separates a real restart from a spurious one. Gating tests drop the card enable in the middle of a high phase, to catch a shortened pulse. Reset tests measure each pulse width and confirm which fields a host reset clears and which it keeps.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
  localparam int DIV_W     = 10;
  localparam int TMO_W     = 4;
  localparam int NUM_RST   = 3;
  localparam int B_INT_EN  = 0;
  localparam int B_STABLE  = 1;
  localparam int B_CARD_EN = 2;
  localparam int B_DIV_HI  = 6;
  localparam int B_DIV_LO  = 8;
  localparam int B_TMO     = 16;
  localparam int B_RST0    = 24;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             int_en;
    logic             card_en;
    logic [TMO_W-1:0] tmo;
  } ctrl_fields_t;

  function automatic ctrl_fields_t decode_word(input logic [31:0] w);
    ctrl_fields_t f;
    f.div     = {w[B_DIV_HI +: 2], w[B_DIV_LO +: 8]};
    f.int_en  = w[B_INT_EN];
    f.card_en = w[B_CARD_EN];
    f.tmo     = w[B_TMO +: TMO_W];
    return f;
  endfunction
endpackage

// File: rtl/sdclk_rst_pulse.sv
module sdclk_rst_pulse #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active
);
  localparam int CW = $clog2(LEN + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (start)  cnt <= CW'(LEN);
    else if (active) cnt <= cnt - 1'b1;
  end

  assign active = (cnt != '0);

  // R9
  rst_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> active);
endmodule

// File: rtl/sdclk_regs.sv
module sdclk_regs
  import sdclk_pkg::*;
#(
  parameter int RST_CYC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [31:0]        wdata,
  output ctrl_fields_t       fields,
  output logic [NUM_RST-1:0] rst_busy
);
  ctrl_fields_t nxt;
  logic         host_clear;
  logic         unused_bits;

  assign unused_bits = ^{wdata[31:27], wdata[23:20], wdata[5:3], wdata[1]};
  assign nxt         = decode_word(wdata);
  assign host_clear  = (wr && wdata[B_RST0]) || rst_busy[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fields <= '0;
    end else begin
      if (wr) fields <= nxt;
      if (host_clear) begin
        fields.div     <= '0;
        fields.int_en  <= 1'b0;
        fields.card_en <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < NUM_RST; g++) begin : g_rst
    sdclk_rst_pulse #(.LEN(RST_CYC)) u_pulse (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (wr && wdata[B_RST0 + g]),
      .active (rst_busy[g])
    );
  end

  // R10
  host_clears_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_busy[0] |-> (fields.div == '0 && !fields.int_en && !fields.card_en));
endmodule

// File: rtl/sdclk_settle.sv
module sdclk_settle
  import sdclk_pkg::*;
#(
  parameter int SETTLE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             int_en,
  input  logic [DIV_W-1:0] div,
  output logic             stable
);
  localparam int CW = $clog2(SETTLE + 1);
  logic [CW-1:0]    cnt;
  logic [DIV_W-1:0] div_prev;
  logic             en_prev;
  logic             restart;

  assign restart = (div != div_prev) || (int_en && !en_prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      div_prev <= '0;
      en_prev  <= 1'b0;
    end else begin
      div_prev <= div;
      en_prev  <= int_en;
      if (restart || !int_en)       cnt <= '0;
      else if (cnt != CW'(SETTLE))  cnt <= cnt + 1'b1;
    end
  end

  assign stable = int_en && (cnt == CW'(SETTLE)) && !restart;

  // R5
  stable_drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stable && !(div != div_prev) && int_en) |-> ##0 1'b1 ##1 (stable || restart || !int_en));
endmodule

// File: rtl/sdclk_divider.sv
module sdclk_divider
  import sdclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_req,
  input  logic [DIV_W-1:0] lim,
  output logic             div_q
);
  logic [DIV_W-1:0] cnt;
  logic             term;

  assign term = ({1'b0, cnt} + 1'b1) >= {1'b0, lim};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      div_q <= 1'b0;
    end else if (!div_q && !run_req) begin
      cnt <= '0;
    end else if (term) begin
      cnt   <= '0;
      div_q <= ~div_q;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R6
  idle_stays_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_req && !div_q) |=> !div_q);
endmodule

// File: rtl/sdclk_ctrl.sv
module sdclk_ctrl
  import sdclk_pkg::*;
#(
  parameter int SETTLE_CYC = 8,
  parameter int RST_CYC    = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_wr,
  input  logic [31:0] ctrl_wdata,
  output logic [31:0] ctrl_rdata,
  output logic        card_clk,
  output logic        clk_stable,
  output logic        host_rst,
  output logic        cmd_rst,
  output logic        data_rst
);
  ctrl_fields_t       f;
  logic [NUM_RST-1:0] busy;
  logic               stable;
  logic               div_zero;
  logic               div_q;
  logic               zero_gate;

  sdclk_regs #(.RST_CYC(RST_CYC)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (ctrl_wr),
    .wdata    (ctrl_wdata),
    .fields   (f),
    .rst_busy (busy)
  );

  sdclk_settle #(.SETTLE(SETTLE_CYC)) u_settle (
    .clk    (clk),
    .rst_n  (rst_n),
    .int_en (f.int_en),
    .div    (f.div),
    .stable (stable)
  );

  assign div_zero = (f.div == '0);

  sdclk_divider u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_req (f.card_en && stable && !div_zero),
    .lim     (f.div),
    .div_q   (div_q)
  );

  // pass-through gate changes only while the base clock is low
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) zero_gate <= 1'b0;
    else        zero_gate <= f.card_en && stable && div_zero && !div_q;
  end

  assign card_clk = (clk && zero_gate) || div_q;

  always_comb begin
    ctrl_rdata                 = '0;
    ctrl_rdata[B_INT_EN]       = f.int_en;
    ctrl_rdata[B_STABLE]       = stable;
    ctrl_rdata[B_CARD_EN]      = f.card_en;
    ctrl_rdata[B_DIV_HI +: 2]  = f.div[DIV_W-1 -: 2];
    ctrl_rdata[B_DIV_LO +: 8]  = f.div[7:0];
    ctrl_rdata[B_TMO +: TMO_W] = f.tmo;
    ctrl_rdata[B_RST0 +: NUM_RST] = busy;
  end

  assign clk_stable = stable;
  assign host_rst   = busy[0];
  assign cmd_rst    = busy[1];
  assign data_rst   = busy[2];

  // R3
  no_path_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(zero_gate && div_q));

  // R6
  gated_when_unstable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stable && !div_q) |=> !div_q);
endmodule

// File: tb/tb_sdclk_ctrl.sv
module tb_sdclk_ctrl;
  localparam int SETTLE = 8;
  localparam int RCYC   = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_wr = 1'b0;
  logic [31:0] ctrl_wdata = '0;
  logic [31:0] ctrl_rdata;
  logic        card_clk, clk_stable, host_rst, cmd_rst, data_rst;
  int          n_vec = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  sdclk_ctrl #(.SETTLE_CYC(SETTLE), .RST_CYC(RCYC)) dut (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .ctrl_rdata(ctrl_rdata), .card_clk(card_clk), .clk_stable(clk_stable),
    .host_rst(host_rst), .cmd_rst(cmd_rst), .data_rst(data_rst));

  function automatic logic [31:0] word(input int d, input bit ie, input bit ce,
                                       input int tmo);
    logic [9:0] dv = 10'(d);
    logic [31:0] w = '0;
    w[15:8]  = dv[7:0];
    w[7:6]   = dv[9:8];
    w[19:16] = 4'(tmo);
    w[2]     = ce;
    w[0]     = ie;
    return w;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic write(input logic [31:0] w);
    ctrl_wdata = w; ctrl_wr = 1'b1;
    tick();
    ctrl_wr = 1'b0;
  endtask

  task automatic settle();
    repeat (SETTLE + 1) tick();
  endtask

  task automatic measure(input int n, output int hi, output int lo);
    int guard = 0;
    hi = 0; lo = 0;
    while (card_clk && guard < 4*n + 40) begin tick(); guard++; end
    while (!card_clk && guard < 8*n + 80) begin tick(); guard++; end
    while (card_clk && hi < 4*n + 8) begin tick(); hi++; end
    while (!card_clk && lo < 4*n + 8) begin tick(); lo++; end
  endtask

  task automatic run_div(input int n, input string tag);
    int hi, lo;
    write(word(n, 1, 1, 3));
    settle();
    check({tag, " stable"}, 32'(clk_stable), 32'd1);
    check({tag, " R1 readback"}, ctrl_rdata, word(n, 1, 1, 3) | 32'h2);
    measure(n, hi, lo);
    check({tag, " R2 high"}, 32'(hi), 32'(n));
    check({tag, " R2 low"}, 32'(lo), 32'(n));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int hi, lo, cnt;
    void'($urandom(32'd4242));
    repeat (3) tick();
    // R11 reset state
    check("R11 rdata", ctrl_rdata, 32'h0);
    check("R11 card_clk", {28'd0, card_clk, clk_stable, host_rst, cmd_rst}, 32'h0);
    rst_n = 1'b1;
    tick();

    // R4 stable timing
    write(word(5, 1, 0, 0));
    check("R4 low after write", 32'(clk_stable), 32'd0);
    repeat (SETTLE) tick();
    check("R4 not yet", 32'(clk_stable), 32'd0);
    tick();
    check("R4 rises", 32'(clk_stable), 32'd1);
    check("R4 bit1", 32'(ctrl_rdata[1]), 32'd1);

    // R6 gated while card enable is 0
    cnt = 0;
    for (int i = 0; i < 30; i++) begin tick(); cnt += card_clk; end
    check("R6 gated ce=0", 32'(cnt), 32'd0);

    // R5 same divisor keeps stable, new divisor drops it
    write(word(5, 1, 0, 0));
    check("R5 same div", 32'(clk_stable), 32'd1);
    write(word(6, 1, 0, 0));
    check("R5 new div", 32'(clk_stable), 32'd0);
    settle();
    write(word(6, 0, 0, 0));
    check("R5 int_en off", 32'(clk_stable), 32'd0);

    // R2 directed and random divisors
    run_div(1, "d1");
    run_div(1023, "d1023");
    for (int k = 0; k < 14; k++) begin
      int n = (k % 5 == 4) ? int'($urandom_range(100, 300)) : int'($urandom_range(2, 24));
      run_div(n, "rand");
    end

    // R6 card enable dropped during a high phase
    write(word(7, 1, 1, 0));
    settle();
    while (card_clk) tick();
    while (!card_clk) tick();
    hi = 1;
    write(word(7, 1, 0, 0));
    while (card_clk && hi < 40) begin tick(); hi++; end
    check("R6 full high", 32'(hi), 32'd7);
    cnt = 0;
    for (int i = 0; i < 40; i++) begin tick(); cnt += card_clk; end
    check("R6 stopped", 32'(cnt), 32'd0);

    // R3 pass-through
    write(word(0, 1, 1, 0));
    settle();
    tick();
    cnt = 0;
    for (int i = 0; i < 6; i++) begin
      cnt += card_clk;
      @(negedge clk); #2;
      cnt += (card_clk ? 0 : 1);
      tick();
    end
    check("R3 pass-through", 32'(cnt), 32'd12);

    // R7 bit 5 and bit 1 ignored, unused bits zero
    write(word(9, 1, 0, 0) | 32'hF8E0_003A);
    check("R7 readback", ctrl_rdata & 32'hF8E0_003A, 32'h0);

    // R8 timeout field
    write(word(9, 1, 0, 11));
    check("R8 tmo", 32'(ctrl_rdata[19:16]), 32'd11);

    // R9 command and data pulses
    write(32'(1) << 25);
    check("R9 cmd bit", 32'(ctrl_rdata[26:24]), 32'b010);
    cnt = 0;
    while (cmd_rst && cnt < 20) begin tick(); cnt++; end
    check("R9 cmd width", 32'(cnt), 32'(RCYC));
    check("R9 cmd clear", 32'(ctrl_rdata[25]), 32'd0);
    write(32'(1) << 26);
    cnt = 0;
    while (data_rst && cnt < 20) begin tick(); cnt++; end
    check("R9 data width", 32'(cnt), 32'(RCYC));

    // R10 host reset
    write(word(12, 1, 1, 6));
    settle();
    write((32'(1) << 24) | word(0, 0, 0, 6));
    check("R10 fields cleared", ctrl_rdata & 32'h000F_FFFF, word(0, 0, 0, 6));
    check("R9 host bit", 32'(ctrl_rdata[24]), 32'd1);
    write(word(33, 1, 1, 6));
    check("R10 held during reset", 32'(ctrl_rdata[15:0]), 32'd0);
    cnt = 1;
    while (host_rst && cnt < 20) begin tick(); cnt++; end
    check("R9 host width", 32'(cnt), 32'(RCYC));
    check("R8 tmo kept", 32'(ctrl_rdata[19:16]), 32'd6);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule